// File: doc/BRIEF.md
# Packed Lane Shuffle and Width Converter

This block rearranges and resizes the four lanes of a packed operand. The lanes are either four bytes held in the low 32 bits of the operand or four 16-bit words that fill all 64 bits. A caller can permute them in one of two ways. One is a fixed 16-entry pattern table indexed by a 4-bit immediate; the table includes four broadcast patterns. The other is an 8-bit mask of four 2-bit source-lane fields. The block can also widen four bytes into four words, with each byte placed in the upper half of its word. It can narrow four words back to four bytes by keeping the upper half of each word.

When the operation consumes a 64-bit source, an optional half-swap exchanges the two 32-bit halves of the operand before the operation is applied. This handles data that arrives with its 32-bit halves in the opposite order. Each accepted request produces one registered result on the following clock edge.

Top module: `lane_shuffle_conv`

## Requirements
- R1: While `rst_n` is low, and until the first accepted request, `res_valid` is 0 and `res_data` is all zeros.
- R2: A request with `req_valid`=1 sampled at a rising edge gives `res_valid`=1 and its result on `res_data` after that same edge. When `req_valid`=0, `res_valid` is 0 after the edge and `res_data` keeps its previous value.
- R3: The operation code is `req_op`: 0 = move, 1 = immediate shuffle, 2 = mask shuffle, 3 = widen, 4 = narrow. Codes 5 to 7 are reserved and give an all-zero result.
- R4: Lane 0 (X) is the least-significant lane, then Y = lane 1, Z = lane 2, W = lane 3. A pattern written as four letters names the source lanes for destination lanes 0, 1, 2, 3 in that order. Immediate codes 0 to 5 select XYWZ, XZYW, YXZW, YZXW, ZXYW and ZYXW.
- R5: Immediate codes 8 to 13 select WXYZ, WXZY, WYXZ, WYZX, WZXY and WZYX.
- R6: Immediate code 6 copies lane X to all four lanes, 7 copies Y, 14 copies Z and 15 copies W.
- R7: In a mask shuffle, bits [2k+1:2k] of `req_mask` give the source lane of destination lane k.
- R8: For both shuffles, `req_word`=1 uses 16-bit lanes across all 64 bits. `req_word`=0 uses byte lanes taken from bits [31:0], and result bits [63:32] are zero.
- R9: Widen: source byte k, taken from bits [8k+7:8k], goes to result bits [16k+15:16k+8], and result bits [16k+7:16k] are zero.
- R10: Narrow: result bits [8k+7:8k] are source bits [16k+15:16k+8], and result bits [63:32] are zero.
- R11: With `req_swap`=1, the operand's halves [63:32] and [31:0] are exchanged before a move, a word shuffle or a narrow.
- R12: `req_swap` has no effect on widen or on byte shuffles, which read only the low 32 bits of the unswapped operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code |
| req_word | input | 1 | Shuffle lane size: 1 = 16-bit, 0 = byte |
| req_swap | input | 1 | Exchange 32-bit halves of a 64-bit source |
| req_imm | input | 4 | Pattern table index for immediate shuffle |
| req_mask | input | 8 | Four 2-bit source-lane fields for mask shuffle |
| req_data | input | 64 | Packed operand |
| res_valid | output | 1 | Result present |
| res_data | output | 64 | Registered result |

## Verification
The half-swap and the lane permutation can act on the same request. Their order matters: the swap moves lanes Z and W into positions X and Y before the shuffle reads them. The bench drives word shuffles and narrows with `req_swap`=1, on operands whose 16-bit lanes all hold different values. It compares the results against a model that swaps first and then permutes, so a design that applies the two steps in the other order, or skips the swap, produces a visibly different lane order. The same swap flag on widen and byte shuffles is checked to leave the result exactly as it is without the flag.

// File: rtl/ls_pkg.sv
package ls_pkg;

  localparam int LS_LANES = 4;
  localparam int LS_IDX_W = $clog2(LS_LANES);
  localparam int LS_SEL_W = LS_LANES * LS_IDX_W;

  localparam logic [2:0] OP_MOVE   = 3'd0;
  localparam logic [2:0] OP_SHUF_I = 3'd1;
  localparam logic [2:0] OP_SHUF_M = 3'd2;
  localparam logic [2:0] OP_WIDEN  = 3'd3;
  localparam logic [2:0] OP_NARROW = 3'd4;

  // Pattern table: result packs {dest3, dest2, dest1, dest0} source indices.
  function automatic logic [LS_SEL_W-1:0] imm_to_sel(input logic [3:0] code);
    logic [LS_SEL_W-1:0] s;
    case (code)
      4'd0:  s = {2'd2, 2'd3, 2'd1, 2'd0};
      4'd1:  s = {2'd3, 2'd1, 2'd2, 2'd0};
      4'd2:  s = {2'd3, 2'd2, 2'd0, 2'd1};
      4'd3:  s = {2'd3, 2'd0, 2'd2, 2'd1};
      4'd4:  s = {2'd3, 2'd1, 2'd0, 2'd2};
      4'd5:  s = {2'd3, 2'd0, 2'd1, 2'd2};
      4'd6:  s = {2'd0, 2'd0, 2'd0, 2'd0};
      4'd7:  s = {2'd1, 2'd1, 2'd1, 2'd1};
      4'd8:  s = {2'd2, 2'd1, 2'd0, 2'd3};
      4'd9:  s = {2'd1, 2'd2, 2'd0, 2'd3};
      4'd10: s = {2'd2, 2'd0, 2'd1, 2'd3};
      4'd11: s = {2'd0, 2'd2, 2'd1, 2'd3};
      4'd12: s = {2'd1, 2'd0, 2'd2, 2'd3};
      4'd13: s = {2'd0, 2'd1, 2'd2, 2'd3};
      4'd14: s = {2'd2, 2'd2, 2'd2, 2'd2};
      default: s = {2'd3, 2'd3, 2'd3, 2'd3};
    endcase
    return s;
  endfunction

  function automatic logic is_broadcast(input logic [3:0] code);
    return (code == 4'd6) || (code == 4'd7) || (code == 4'd14) || (code == 4'd15);
  endfunction

  // True when the operation reads a full 64-bit operand.
  function automatic logic reads_wide(input logic [2:0] op, input logic word_lanes);
    return (op == OP_MOVE) || (op == OP_NARROW) ||
           (((op == OP_SHUF_I) || (op == OP_SHUF_M)) && word_lanes);
  endfunction

  function automatic logic is_shuffle(input logic [2:0] op);
    return (op == OP_SHUF_I) || (op == OP_SHUF_M);
  endfunction

endpackage

// File: rtl/ls_half_swap.sv
module ls_half_swap #(
  parameter int HALF_W = 32
) (
  input  logic              en,
  input  logic [2*HALF_W-1:0] din,
  output logic [2*HALF_W-1:0] dout
);
  assign dout = en ? {din[HALF_W-1:0], din[2*HALF_W-1:HALF_W]} : din;
endmodule

// File: rtl/ls_lane_permute.sv
module ls_lane_permute #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [LANES*LANE_W-1:0] src,
  input  logic [LANES*IDX_W-1:0]  sel,
  output logic [LANES*LANE_W-1:0] dst,
  output logic [LANES-1:0]        used
);
  logic [LANE_W-1:0] lane_q [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_q[g] = src[g*LANE_W +: LANE_W];
    assign dst[g*LANE_W +: LANE_W] = lane_q[sel[g*IDX_W +: IDX_W]];
  end

  // Which source lanes feed at least one destination lane.
  always_comb begin
    used = '0;
    for (int k = 0; k < LANES; k++) used[sel[k*IDX_W +: IDX_W]] = 1'b1;
  end
endmodule

// File: rtl/ls_width_conv.sv
module ls_width_conv #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic [LANES*BYTE_W-1:0] byte_src,
  input  logic [LANES*WORD_W-1:0] word_src,
  output logic [LANES*WORD_W-1:0] widened,
  output logic [LANES*BYTE_W-1:0] narrowed
);
  for (genvar g = 0; g < LANES; g++) begin : g_conv
    assign widened[g*WORD_W +: WORD_W]  = {byte_src[g*BYTE_W +: BYTE_W], {BYTE_W{1'b0}}};
    assign narrowed[g*BYTE_W +: BYTE_W] = word_src[g*WORD_W + BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/lane_shuffle_conv.sv
module lane_shuffle_conv
  import ls_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int DATA_W = LS_LANES * WORD_W,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic              req_word,
  input  logic              req_swap,
  input  logic [3:0]        req_imm,
  input  logic [7:0]        req_mask,
  input  logic [DATA_W-1:0] req_data,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data
);

  logic                swap_fire;
  logic [DATA_W-1:0]   op_data;
  logic [LS_SEL_W-1:0] lane_sel;
  logic [DATA_W-1:0]   word_perm;
  logic [HALF_W-1:0]   byte_perm;
  logic [LS_LANES-1:0] word_used;
  logic [LS_LANES-1:0] byte_used;
  logic [LS_LANES-1:0] lane_used;
  logic [DATA_W-1:0]   widened;
  logic [HALF_W-1:0]   narrowed;
  logic [DATA_W-1:0]   next_res;
  logic [2:0]          res_op;
  logic                res_word;
  logic                armed;

  assign swap_fire = req_swap && reads_wide(req_op, req_word);

  ls_half_swap #(.HALF_W(HALF_W)) i_swap (
    .en  (swap_fire),
    .din (req_data),
    .dout(op_data)
  );

  assign lane_sel = (req_op == OP_SHUF_I) ? imm_to_sel(req_imm) : req_mask;

  ls_lane_permute #(.LANES(LS_LANES), .LANE_W(WORD_W)) i_perm_word (
    .src (op_data),
    .sel (lane_sel),
    .dst (word_perm),
    .used(word_used)
  );

  ls_lane_permute #(.LANES(LS_LANES), .LANE_W(BYTE_W)) i_perm_byte (
    .src (op_data[HALF_W-1:0]),
    .sel (lane_sel),
    .dst (byte_perm),
    .used(byte_used)
  );

  assign lane_used = req_word ? word_used : byte_used;

  ls_width_conv #(.LANES(LS_LANES), .BYTE_W(BYTE_W)) i_conv (
    .byte_src(op_data[HALF_W-1:0]),
    .word_src(op_data),
    .widened (widened),
    .narrowed(narrowed)
  );

  always_comb begin
    next_res = '0;
    case (req_op)
      OP_MOVE:              next_res = op_data;
      OP_SHUF_I, OP_SHUF_M: next_res = req_word ? word_perm : {{HALF_W{1'b0}}, byte_perm};
      OP_WIDEN:             next_res = widened;
      OP_NARROW:            next_res = {{HALF_W{1'b0}}, narrowed};
      default:              next_res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_op    <= OP_MOVE;
      res_word  <= 1'b0;
      armed     <= 1'b0;
    end else begin
      armed     <= 1'b1;
      res_valid <= req_valid;
      if (req_valid) begin
        res_data <= next_res;
        res_op   <= req_op;
        res_word <= req_word;
      end
    end
  end

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (res_valid == $past(req_valid)));  // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(req_valid)) |-> $stable(res_data));  // R2
  AST_TABLE_FULL_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_SHUF_I && !is_broadcast(req_imm)) |-> (lane_used == '1));  // R4
  AST_TABLE_BCAST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_SHUF_I && is_broadcast(req_imm)) |-> ($countones(lane_used) == 1));  // R6
  AST_WIDEN_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_op == OP_WIDEN) |->
      (res_data[7:0] == 8'h0 && res_data[23:16] == 8'h0 &&
       res_data[39:32] == 8'h0 && res_data[55:48] == 8'h0));  // R9
  AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_op == OP_NARROW) |-> (res_data[DATA_W-1:HALF_W] == '0));  // R10
  AST_BYTE_SHUF_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && is_shuffle(res_op) && !res_word) |-> (res_data[DATA_W-1:HALF_W] == '0));  // R8
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_op > OP_NARROW) |-> (res_data == '0));  // R3

endmodule

// File: tb/test_lane_shuffle_conv.sv
`timescale 1ns/1ps
module test_lane_shuffle_conv;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic        req_word = 1'b0;
  logic        req_swap = 1'b0;
  logic [3:0]  req_imm = '0;
  logic [7:0]  req_mask = '0;
  logic [63:0] req_data = '0;
  logic        res_valid;
  logic [63:0] res_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lane_shuffle_conv i_lane_shuffle_conv (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_word(req_word), .req_swap(req_swap), .req_imm(req_imm),
    .req_mask(req_mask), .req_data(req_data),
    .res_valid(res_valid), .res_data(res_data)
  );

  function automatic string pattern(input logic [3:0] code);
    string p[16] = '{"XYWZ", "XZYW", "YXZW", "YZXW", "ZXYW", "ZYXW", "XXXX", "YYYY",
                     "WXYZ", "WXZY", "WYXZ", "WYZX", "WZXY", "WZYX", "ZZZZ", "WWWW"};
    return p[code];
  endfunction

  function automatic int letter_idx(input byte c);
    case (c)
      "X": return 0;
      "Y": return 1;
      "Z": return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [63:0] model(input logic [2:0] op, input logic wd, input logic sw,
                                        input logic [3:0] imm, input logic [7:0] mask,
                                        input logic [63:0] d);
    logic [63:0] s, r;
    int src;
    string pat;
    s = d;
    r = '0;
    if (sw && (op == 0 || op == 4 || ((op == 1 || op == 2) && wd))) s = {d[31:0], d[63:32]};
    pat = pattern(imm);
    case (op)
      3'd0: r = s;
      3'd1, 3'd2: for (int k = 0; k < 4; k++) begin
        src = (op == 1) ? letter_idx(pat[k]) : int'(mask[2*k +: 2]);
        if (wd) r[16*k +: 16] = s[16*src +: 16];
        else    r[8*k +: 8]   = s[8*src +: 8];
      end
      3'd3: for (int k = 0; k < 4; k++) r[16*k +: 16] = {s[8*k +: 8], 8'h00};
      3'd4: for (int k = 0; k < 4; k++) r[8*k +: 8] = s[16*k + 8 +: 8];
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input logic v, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (v !== 1'b1 || got !== exp) begin
      errors++;
      $display("FAIL %s: valid=%0b actual=%h expected=%h", tag, v, got, exp);
    end
  endtask

  task automatic run(input string tag, input logic [2:0] op, input logic wd, input logic sw,
                     input logic [3:0] imm, input logic [7:0] mask, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_word = wd; req_swap = sw;
    req_imm = imm; req_mask = mask; req_data = d;
    @(negedge clk);
    check(tag, res_valid, res_data, model(op, wd, sw, imm, mask, d));
    req_valid = 1'b0;
  endtask

  localparam logic [63:0] WD = 64'hD4C4_B3A3_9282_7161;

  initial begin
    logic [63:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    checks++;
    if (res_valid !== 1'b0 || res_data !== 64'h0) begin
      errors++;
      $display("FAIL R1: valid=%0b data=%h expected valid=0 data=0", res_valid, res_data);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (res_valid !== 1'b0 || res_data !== 64'h0) begin
      errors++;
      $display("FAIL R1: idle after reset valid=%0b data=%h expected 0/0", res_valid, res_data);
    end

    for (int c = 0; c < 16; c++) begin
      string t;
      t = (c < 6) ? "R4 word" : (c == 6 || c == 7 || c >= 14) ? "R6 word" : "R5 word";
      run(t, 3'd1, 1'b1, 1'b0, 4'(c), 8'h00, WD);
      t = (c < 6) ? "R4 R8 byte" : (c == 6 || c == 7 || c >= 14) ? "R6 R8 byte" : "R5 R8 byte";
      run(t, 3'd1, 1'b0, 1'b0, 4'(c), 8'h00, WD);
    end
    run("R7 mask word", 3'd2, 1'b1, 1'b0, 4'd0, 8'b00_01_10_11, WD);
    run("R7 mask byte", 3'd2, 1'b0, 1'b0, 4'd0, 8'b01_01_11_10, WD);
    run("R9 widen", 3'd3, 1'b0, 1'b0, 4'd0, 8'h00, 64'h1122_3344_A1B2_C3D4);
    run("R10 narrow", 3'd4, 1'b0, 1'b0, 4'd0, 8'h00, 64'hF0E1_D2C3_B4A5_9687);
    run("R11 move swap", 3'd0, 1'b0, 1'b1, 4'd0, 8'h00, WD);
    run("R11 word shuffle swap", 3'd1, 1'b1, 1'b1, 4'd3, 8'h00, WD);
    run("R11 mask shuffle swap", 3'd2, 1'b1, 1'b1, 4'd0, 8'b00_11_01_10, WD);
    run("R11 narrow swap", 3'd4, 1'b0, 1'b1, 4'd0, 8'h00, WD);
    run("R12 widen swap", 3'd3, 1'b0, 1'b1, 4'd0, 8'h00, WD);
    run("R12 byte shuffle swap", 3'd1, 1'b0, 1'b1, 4'd8, 8'h00, WD);
    run("R3 move", 3'd0, 1'b0, 1'b0, 4'd0, 8'h00, WD);
    for (int o = 5; o < 8; o++) run("R3 reserved", 3'(o), 1'b1, 1'b1, 4'd2, 8'hA5, WD);

    run("R2 load", 3'd0, 1'b0, 1'b0, 4'd0, 8'h00, 64'h0123_4567_89AB_CDEF);
    held = res_data;
    @(negedge clk);
    req_data = 64'hFFFF_0000_FFFF_0000; req_op = 3'd0;
    @(negedge clk);
    checks++;
    if (res_valid !== 1'b0 || res_data !== held) begin
      errors++;
      $display("FAIL R2: hold valid=%0b actual=%h expected=%h", res_valid, res_data, held);
    end

    for (int n = 0; n < 400; n++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      run("R3 random", op, 1'($urandom), 1'($urandom), 4'($urandom), 8'($urandom),
          {$urandom, $urandom});
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule